// File: doc/BRIEF.md
# Nibble-coded I2C command sequencer

This block is an I2C master that runs a small stored program instead of taking byte-level requests. Software packs 4-bit bus micro-commands into a command memory, two per byte. It then writes a control word that names a start nibble address and sets a run bit. From that point the sequencer fetches one command at a time. Each command raises or lowers one bus line, clocks a single data bit out or in, checks an acknowledge, or waits.

Both bus lines are open drain. The block only ever pulls a line low or releases it. Bits that arrive during read commands are assembled MSB first. Each finished byte is written to a read buffer, starting at offset 0 and running on across every read phase of the program. A status nibble reports whether a sequence is running, two error causes, and whether a program is missing. A reset bit in the control word aborts any run at once.

Top module: `nib_i2c_seq`

## Requirements
- R1: After reset both lines are released (`sclOe`=0, `sdaOe`=0) and `status` reads 4'b1000.
- R2: The command codes are END=0, ADDRESS=1, CLOCK_L=2, CLOCK_H=3, DATA_L=4, DATA_H=5, RESET=6, SLEEP=7, DATA_L_NOP=8, DATA_H_NOP=0xC, DATA_H_READ=0xD, DATA_H_ACK0=0xE and DATA_H_ACK1=0xF. Each memory byte holds two commands, and the one at the even nibble address runs first from bits 3:0.
- R3: Writing the control word with bit 16 set and bit 17 clear starts execution at the nibble address in bits MEM_AW:0. The request is ignored while a sequence runs, and also while status bit 3 is set.
- R4: Writing the control word with bit 17 set aborts the sequencer and takes priority over bit 16. On the next cycle both lines are released and `status` reads 4'b1000.
- R5: CLOCK_L, CLOCK_H, DATA_L and DATA_H each change only their own line and then hold for one quarter period. The sequence DATA_H, CLOCK_H, DATA_L, CLOCK_L forms a START condition, and DATA_L, CLOCK_H, DATA_H forms a STOP condition.
- R6: Each of DATA_L_NOP, DATA_H_NOP, DATA_H_READ, DATA_H_ACK0 and DATA_H_ACK1 makes one SCL pulse, low-high-low, lasting four quarter periods of QUARTER_CYC clocks each. SDA is pulled low for the whole pulse by DATA_L_NOP and released by the other four.
- R7: DATA_H_READ samples SDA at the end of the SCL high time, MSB first. Every 8 samples form a byte, which is stored at the next read-buffer offset. The offset restarts at 0 with each run.
- R8: If DATA_H_ACK0 samples SDA high, status bit 1 is set, a STOP is driven, and running clears. DATA_H_ACK1 performs no check.
- R9: END clears running and leaves both lines as they are.
- R10: SLEEP holds both lines for SLEEP_BITS bit periods. ADDRESS, RESET and the unassigned codes 9 to 0xB are no-operations.
- R11: If a command that is not END completes at the last nibble address of the memory, status bit 2 is set, a STOP is driven, and running clears.
- R12: Status bit 3 is set by reset and by an abort, and any command memory write clears it. The error bits are cleared when a run starts and otherwise stay unchanged while idle. Status bit 0 is never set while bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memWe | input | 1 | Command memory byte write strobe |
| memAddr | input | MEM_AW | Command memory byte address |
| memData | input | 8 | Command byte, earlier command in bits 3:0 |
| ctlWe | input | 1 | Control word write strobe |
| ctlData | input | 32 | Control word: bit 17 abort, bit 16 run, low bits start nibble |
| rdAddr | input | RD_AW | Read buffer offset |
| rdData | output | 8 | Read buffer byte at `rdAddr` |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| status | output | 4 | {no program, end overrun error, ack error, running} |

## Verification
A wrong command pointer or a wrong nibble choice appears on the bus within one quarter period. The observed bit order would differ from the packed program, or extra or missing SCL pulses would show up, and the STOP count and the pulse count at the end of each run expose it. A slip in the read shift or the buffer offset appears as wrong bytes at offsets 0 and 1 once the run ends. A lost acknowledge result, or a missed end-of-memory check, leaves status reading 0 instead of 2 or 4 at idle. A broken abort path shows on the very next cycle as a line still pulled low or running still set.

// File: rtl/nib_i2c_pkg.sv
package nib_i2c_pkg;

  typedef enum logic [3:0] {
    CMD_END     = 4'h0,
    CMD_ADDR    = 4'h1,
    CMD_SCL_LO  = 4'h2,
    CMD_SCL_HI  = 4'h3,
    CMD_SDA_LO  = 4'h4,
    CMD_SDA_HI  = 4'h5,
    CMD_RST     = 4'h6,
    CMD_SLEEP   = 4'h7,
    CMD_BIT0    = 4'h8,
    CMD_BIT1    = 4'hC,
    CMD_RDBIT   = 4'hD,
    CMD_ACKCHK  = 4'hE,
    CMD_ACKFREE = 4'hF
  } cmdE;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_LINE, ST_BQ0, ST_BQ1, ST_BQ2, ST_BQ3,
    ST_SLEEP, ST_STP0, ST_STP1, ST_STP2
  } stateE;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPtr;
    logic incPtr;
    logic timerClr;
    logic setScl;
    logic sclLow;
    logic setSda;
    logic sdaLow;
    logic shiftIn;
    logic rdClr;
  } strobeT;

endpackage

// File: rtl/nib_i2c_dp.sv
module nib_i2c_dp
  import nib_i2c_pkg::*;
#(
  parameter int MEM_AW      = 6,
  parameter int RD_AW       = 4,
  parameter int QUARTER_CYC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memWe,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic [7:0]        memData,
  input  logic [MEM_AW:0]   startNib,
  input  strobeT            stb,
  input  logic              sdaIn,
  input  logic [RD_AW-1:0]  rdAddr,
  output logic [7:0]        rdData,
  output logic [3:0]        cmd,
  output logic              ptrLast,
  output logic              quarterTick,
  output logic              sclOe,
  output logic              sdaOe
);
  localparam int NIB_W     = MEM_AW + 1;
  localparam int MEM_BYTES = 1 << MEM_AW;
  localparam int RD_BYTES  = 1 << RD_AW;
  localparam int TW        = (QUARTER_CYC > 2) ? $clog2(QUARTER_CYC) : 1;

  logic [7:0]       cmdMem [MEM_BYTES];
  logic [7:0]       rdBuf  [RD_BYTES];
  logic [NIB_W-1:0] ptr;
  logic [TW-1:0]    timer;
  logic [6:0]       rxShift;
  logic [2:0]       bitCnt;
  logic [RD_AW-1:0] rdPtr;
  logic             sclLowQ, sdaLowQ;
  logic [7:0]       cmdByte;

  always_ff @(posedge clk) begin
    if (memWe) cmdMem[memAddr] <= memData;
  end

  assign cmdByte = cmdMem[ptr[NIB_W-1:1]];
  assign cmd     = ptr[0] ? cmdByte[7:4] : cmdByte[3:0];
  assign ptrLast = &ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (stb.loadPtr) ptr <= startNib;
    else if (stb.incPtr) ptr <= ptr + 1'b1;
  end

  assign quarterTick = (timer == TW'(QUARTER_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timer <= '0;
    else if (stb.timerClr || quarterTick) timer <= '0;
    else timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLowQ <= 1'b0;
      sdaLowQ <= 1'b0;
    end else begin
      if (stb.setScl) sclLowQ <= stb.sclLow;
      if (stb.setSda) sdaLowQ <= stb.sdaLow;
    end
  end

  assign sclOe = sclLowQ;
  assign sdaOe = sdaLowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
      rdPtr   <= '0;
    end else if (stb.rdClr) begin
      bitCnt <= '0;
      rdPtr  <= '0;
    end else if (stb.shiftIn) begin
      rxShift <= {rxShift[5:0], sdaIn};
      bitCnt  <= bitCnt + 1'b1;
      if (bitCnt == 3'd7) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!stb.rdClr && stb.shiftIn && bitCnt == 3'd7)
      rdBuf[rdPtr] <= {rxShift, sdaIn};
  end

  assign rdData = rdBuf[rdAddr];

endmodule

// File: rtl/nib_i2c_ctrl.sv
module nib_i2c_ctrl
  import nib_i2c_pkg::*;
#(
  parameter int SLEEP_BITS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runReq,
  input  logic       rstReq,
  input  logic       memWe,
  input  logic [3:0] cmd,
  input  logic       ptrLast,
  input  logic       quarterTick,
  input  logic       sdaIn,
  output strobeT     stb,
  output logic [3:0] status
);
  localparam int SLP_Q = SLEEP_BITS * 4;
  localparam int SW    = $clog2(SLP_Q + 1);

  stateE         state, nextState;
  logic [3:0]    curCmd;
  logic          errAck, errEnd, noSeq;
  logic [SW-1:0] sleepCnt;
  logic          doAdv, goStop, runOk, ackFail, endErr;

  assign runOk   = runReq && !rstReq && !noSeq && (state == ST_IDLE);
  assign ackFail = (state == ST_BQ2) && quarterTick && (curCmd == CMD_ACKCHK) && sdaIn;

  always_comb begin
    stb       = '0;
    nextState = state;
    doAdv     = 1'b0;
    goStop    = 1'b0;
    if (rstReq) begin
      nextState = ST_IDLE;
      stb.setScl = 1'b1;
      stb.setSda = 1'b1;
      stb.rdClr  = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (runOk) begin
          stb.loadPtr = 1'b1;
          stb.rdClr   = 1'b1;
          nextState   = ST_FETCH;
        end
        ST_FETCH: begin
          stb.timerClr = 1'b1;
          case (cmd)
            CMD_END: nextState = ST_IDLE;
            CMD_SCL_LO, CMD_SCL_HI: begin
              stb.setScl = 1'b1;
              stb.sclLow = (cmd == CMD_SCL_LO);
              nextState  = ST_LINE;
            end
            CMD_SDA_LO, CMD_SDA_HI: begin
              stb.setSda = 1'b1;
              stb.sdaLow = (cmd == CMD_SDA_LO);
              nextState  = ST_LINE;
            end
            CMD_SLEEP: nextState = ST_SLEEP;
            CMD_BIT0, CMD_BIT1, CMD_RDBIT, CMD_ACKCHK, CMD_ACKFREE: begin
              stb.setScl = 1'b1;
              stb.sclLow = 1'b1;
              stb.setSda = 1'b1;
              stb.sdaLow = (cmd == CMD_BIT0);
              nextState  = ST_BQ0;
            end
            default: doAdv = 1'b1;
          endcase
        end
        ST_LINE: if (quarterTick) doAdv = 1'b1;
        ST_BQ0: if (quarterTick) begin
          stb.setScl = 1'b1;
          nextState  = ST_BQ1;
        end
        ST_BQ1: if (quarterTick) nextState = ST_BQ2;
        ST_BQ2: if (quarterTick) begin
          stb.setScl  = 1'b1;
          stb.sclLow  = 1'b1;
          stb.shiftIn = (curCmd == CMD_RDBIT);
          nextState   = ST_BQ3;
        end
        ST_BQ3: if (quarterTick) begin
          if (curCmd == CMD_ACKCHK && errAck) goStop = 1'b1;
          else doAdv = 1'b1;
        end
        ST_SLEEP: if (quarterTick && sleepCnt == '0) doAdv = 1'b1;
        ST_STP0: if (quarterTick) begin
          stb.setScl = 1'b1;
          nextState  = ST_STP1;
        end
        ST_STP1: if (quarterTick) begin
          stb.setSda = 1'b1;
          nextState  = ST_STP2;
        end
        ST_STP2: if (quarterTick) nextState = ST_IDLE;
        default: nextState = ST_IDLE;
      endcase
      if (doAdv) begin
        if (ptrLast) goStop = 1'b1;
        else begin
          stb.incPtr = 1'b1;
          nextState  = ST_FETCH;
        end
      end
      if (goStop) begin
        stb.setScl   = 1'b1;
        stb.sclLow   = 1'b1;
        stb.setSda   = 1'b1;
        stb.sdaLow   = 1'b1;
        stb.timerClr = 1'b1;
        nextState    = ST_STP0;
      end
    end
  end

  assign endErr = doAdv && ptrLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curCmd   <= '0;
      errAck   <= 1'b0;
      errEnd   <= 1'b0;
      noSeq    <= 1'b1;
      sleepCnt <= '0;
    end else begin
      state <= nextState;
      if (rstReq) begin
        errAck <= 1'b0;
        errEnd <= 1'b0;
        noSeq  <= 1'b1;
      end else begin
        if (memWe) noSeq <= 1'b0;
        if (runOk) begin
          errAck <= 1'b0;
          errEnd <= 1'b0;
        end
        if (ackFail) errAck <= 1'b1;
        if (endErr) errEnd <= 1'b1;
      end
      if (state == ST_FETCH) begin
        curCmd   <= cmd;
        sleepCnt <= SW'(SLP_Q - 1);
      end else if (state == ST_SLEEP && quarterTick) begin
        sleepCnt <= sleepCnt - 1'b1;
      end
    end
  end

  assign status = {noSeq, errEnd, errAck, state != ST_IDLE};

endmodule

// File: rtl/nib_i2c_seq.sv
module nib_i2c_seq
  import nib_i2c_pkg::*;
#(
  parameter int MEM_AW      = 6,
  parameter int RD_AW       = 4,
  parameter int QUARTER_CYC = 5,
  parameter int SLEEP_BITS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memWe,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic [7:0]        memData,
  input  logic              ctlWe,
  input  logic [31:0]       ctlData,
  input  logic [RD_AW-1:0]  rdAddr,
  output logic [7:0]        rdData,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [3:0]        status
);
  strobeT     stb;
  logic [3:0] cmd;
  logic       ptrLast, quarterTick;
  logic       runReq, rstReq;

  assign runReq = ctlWe && ctlData[16];
  assign rstReq = ctlWe && ctlData[17];

  nib_i2c_ctrl #(.SLEEP_BITS(SLEEP_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .runReq(runReq), .rstReq(rstReq), .memWe(memWe),
    .cmd(cmd), .ptrLast(ptrLast), .quarterTick(quarterTick), .sdaIn(sdaIn),
    .stb(stb), .status(status)
  );

  nib_i2c_dp #(.MEM_AW(MEM_AW), .RD_AW(RD_AW), .QUARTER_CYC(QUARTER_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .startNib(ctlData[MEM_AW:0]), .stb(stb), .sdaIn(sdaIn), .rdAddr(rdAddr),
    .rdData(rdData), .cmd(cmd), .ptrLast(ptrLast), .quarterTick(quarterTick),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

endmodule

// File: rtl/nib_i2c_seq_chk.sv
module nib_i2c_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memWe,
  input logic        ctlWe,
  input logic [31:0] ctlData,
  input logic [3:0]  status,
  input logic        sclOe,
  input logic        sdaOe
);
  // R4
  abort_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWe && ctlData[17] |=> status == 4'b1000 && !sclOe && !sdaOe);

  // R3
  run_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWe && ctlData[16] && !ctlData[17] && !status[0] && !status[3] |=> status[0]);

  // R12
  noseq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[3] |-> !status[0]);

  // R12
  load_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe && !(ctlWe && ctlData[17]) |=> !status[3]);

  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !status[0] && !ctlWe |=> $stable(status[2:1]));

  // R8
  ack_err_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[1]) |-> status[0]);
endmodule

bind nib_i2c_seq nib_i2c_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .memWe(memWe), .ctlWe(ctlWe), .ctlData(ctlData),
  .status(status), .sclOe(sclOe), .sdaOe(sdaOe)
);

// File: tb/nib_i2c_seq_tb_top.sv
module nib_i2c_seq_tb_top;
  localparam int MEM_AW = 6;
  localparam int RD_AW  = 4;
  localparam int QC     = 5;
  localparam int SLP    = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memWe = 1'b0;
  logic [MEM_AW-1:0] memAddr = '0;
  logic [7:0] memData = '0;
  logic ctlWe = 1'b0;
  logic [31:0] ctlData = '0;
  logic [RD_AW-1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic sclOe, sdaOe;
  logic [3:0] status;
  logic slaveLow = 1'b0;
  logic sdaLine, sclLine;

  int nChk = 0, nErr = 0;
  int rises = 0, starts = 0, stops = 0;
  logic seen [64];
  logic drvLow [64];
  logic [3:0] nibs [128];
  int nn = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign sdaLine = !(sdaOe || slaveLow);
  assign sclLine = !sclOe;

  nib_i2c_seq #(.MEM_AW(MEM_AW), .RD_AW(RD_AW), .QUARTER_CYC(QC), .SLEEP_BITS(SLP)) dut_i (
    .clk(clk), .rstN(rstN), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .ctlWe(ctlWe), .ctlData(ctlData), .rdAddr(rdAddr), .rdData(rdData),
    .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe), .status(status)
  );

  // bus target model: records SDA at each SCL rise, drives per slot after SCL falls
  always @(posedge sclLine) begin
    if (rises < 64) seen[rises] = sdaLine;
    rises++;
  end
  always @(negedge sclLine) slaveLow = (rises < 64) ? drvLow[rises] : 1'b0;
  always @(negedge sdaLine) if (sclLine === 1'b1) starts++;
  always @(posedge sdaLine) if (sclLine === 1'b1) stops++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearBus();
    rises = 0; starts = 0; stops = 0; slaveLow = 1'b0;
    for (int i = 0; i < 64; i++) begin drvLow[i] = 1'b0; seen[i] = 1'b1; end
  endtask

  task automatic addC(input logic [3:0] c); nibs[nn] = c; nn++; endtask
  task automatic addStart(); addC(4'h5); addC(4'h3); addC(4'h4); addC(4'h2); endtask
  task automatic addStop();  addC(4'h4); addC(4'h3); addC(4'h5); endtask
  task automatic addEnd();   addC(4'h0); if (nn % 2) addC(4'h0); endtask
  task automatic addWr(input logic [7:0] b, input logic [3:0] ack);
    for (int i = 7; i >= 0; i--) addC(b[i] ? 4'hC : 4'h8);
    addC(ack);
  endtask
  task automatic addRd(input bit last);
    for (int i = 0; i < 8; i++) addC(4'hD);
    addC(last ? 4'hC : 4'h8);
  endtask

  task automatic loadAt(input int base);
    for (int i = 0; i < nn / 2; i++) begin
      @(negedge clk);
      memWe = 1'b1; memAddr = MEM_AW'(base + i); memData = {nibs[2*i+1], nibs[2*i]};
    end
    @(negedge clk) memWe = 1'b0;
    nn = 0;
  endtask

  task automatic ctlPulse(input logic [31:0] d);
    @(negedge clk); ctlWe = 1'b1; ctlData = d;
    @(negedge clk); ctlWe = 1'b0; ctlData = '0;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    while (status[0] && cyc < 20000) begin @(negedge clk); cyc++; end
  endtask

  function automatic logic [7:0] seenByte(input int off);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7-i] = seen[off+i];
    return b;
  endfunction

  task automatic tReset();
    check(sclOe == 1'b0 && sdaOe == 1'b0, "R1 lines released", {sclOe, sdaOe}, 0);
    check(status == 4'b1000, "R1 status", status, 8);
    clearBus();
    ctlPulse(32'h1_0000);
    repeat (3) @(negedge clk);
    check(status == 4'b1000, "R3 run ignored without program", status, 8);
    check(rises == 0, "R3 no bus activity", rises, 0);
  endtask

  task automatic tWrite();
    int cyc;
    addStart(); addWr(8'hA4, 4'hE); addWr(8'h3C, 4'hE); addStop(); addEnd();
    loadAt(0);
    clearBus(); drvLow[8] = 1'b1; drvLow[17] = 1'b1;
    ctlPulse(32'h1_0000);
    waitIdle(cyc);
    check(status == 4'b0000, "R9 status after END", status, 0);
    check(seenByte(0) == 8'hA4, "R2 R6 first byte bits", seenByte(0), 8'hA4);
    check(seenByte(9) == 8'h3C, "R6 second byte bits", seenByte(9), 8'h3C);
    check(seen[8] == 1'b0 && seen[17] == 1'b0, "R6 ack slots low", {seen[8], seen[17]}, 0);
    check(starts == 1 && stops == 1, "R5 one START one STOP", starts * 16 + stops, 8'h11);
    check(rises == 19, "R6 pulse count", rises, 19);
    check(!sclOe && !sdaOe, "R5 lines released after STOP", {sclOe, sdaOe}, 0);
  endtask

  task automatic tRead(input logic [7:0] b0, input logic [7:0] b1);
    int cyc;
    addStart(); addWr(8'hA5, 4'hE); addRd(1'b0); addRd(1'b1); addStop(); addEnd();
    loadAt(16);
    clearBus(); drvLow[8] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      drvLow[9+i]  = !b0[7-i];
      drvLow[18+i] = !b1[7-i];
    end
    ctlPulse(32'h1_0000 | 32'd32);
    waitIdle(cyc);
    check(status == 4'b0000, "R7 read run status", status, 0);
    rdAddr = '0; #1;
    check(rdData == b0, "R7 byte at offset 0", rdData, b0);
    rdAddr = RD_AW'(1); #1;
    check(rdData == b1, "R7 byte at offset 1", rdData, b1);
    check(seen[17] == 1'b0, "R6 master ack low", seen[17], 0);
    check(seen[26] == 1'b1, "R6 master nack high", seen[26], 1);
    check(rises == 28, "R7 read pulse count", rises, 28);
  endtask

  task automatic tNack();
    int cyc;
    addStart(); addWr(8'h90, 4'hE); addWr(8'h00, 4'hE); addStop(); addEnd();
    loadAt(36);
    clearBus();
    ctlPulse(32'h1_0000 | 32'd72);
    waitIdle(cyc);
    check(status == 4'b0010, "R8 ack error status", status, 2);
    check(rises == 10, "R8 stops after failed ack", rises, 10);
    check(stops == 1, "R8 STOP driven", stops, 1);
    check(!sclOe && !sdaOe, "R8 lines released", {sclOe, sdaOe}, 0);
    addStart(); addWr(8'h90, 4'hF); addStop(); addEnd();
    loadAt(36);
    clearBus();
    ctlPulse(32'h1_0000 | 32'd72);
    waitIdle(cyc);
    check(status == 4'b0000, "R8 unchecked ack no error", status, 0);
    check(rises == 10, "R8 unchecked ack pulse count", rises, 10);
  endtask

  task automatic tLines();
    int cyc;
    addC(4'h1); addC(4'h6); addC(4'h9); addC(4'h4); addEnd(); loadAt(50);
    addC(4'h5); addC(4'h2); addEnd(); loadAt(53);
    addC(4'h3); addEnd(); loadAt(55);
    ctlPulse(32'h1_0000 | 32'd100);
    waitIdle(cyc);
    check(status == 4'b0000, "R10 no-ops run cleanly", status, 0);
    check(sdaOe && !sclOe, "R5 DATA_L only SDA", {sclOe, sdaOe}, 1);
    ctlPulse(32'h1_0000 | 32'd106);
    waitIdle(cyc);
    check(!sdaOe && sclOe, "R5 CLOCK_L only SCL", {sclOe, sdaOe}, 2);
    ctlPulse(32'h1_0000 | 32'd110);
    waitIdle(cyc);
    check(!sdaOe && !sclOe, "R9 CLOCK_H then END holds", {sclOe, sdaOe}, 0);
  endtask

  task automatic tSleep();
    int cyc;
    addC(4'h7); addEnd(); loadAt(56);
    addStart(); addEnd(); loadAt(58);
    clearBus();
    ctlPulse(32'h1_0000 | 32'd112);
    repeat (20) @(negedge clk);
    check(status[0] == 1'b1, "R10 running during SLEEP", status, 1);
    ctlPulse(32'h1_0000 | 32'd116);
    waitIdle(cyc);
    cyc = cyc + 22;
    check(starts == 0 && rises == 0, "R3 run while busy ignored", starts + rises, 0);
    check(cyc >= 4 * SLP * QC && cyc <= 4 * SLP * QC + 10, "R10 sleep length", cyc, 4 * SLP * QC + 2);
  endtask

  task automatic tOverrun();
    int cyc;
    addC(4'h1); addC(4'h1); loadAt(63);
    clearBus();
    ctlPulse(32'h1_0000 | 32'd126);
    waitIdle(cyc);
    check(status == 4'b0100, "R11 end overrun status", status, 4);
    check(stops == 1 && !sclOe && !sdaOe, "R11 STOP after overrun", stops, 1);
  endtask

  task automatic tAbort();
    drvLow[8] = 1'b1;
    clearBus(); drvLow[8] = 1'b1; drvLow[17] = 1'b1;
    ctlPulse(32'h1_0000);
    repeat (60) @(negedge clk);
    check(status[0] == 1'b1, "R4 running before abort", status, 1);
    @(negedge clk); ctlWe = 1'b1; ctlData = 32'h3_0000;
    @(negedge clk); ctlWe = 1'b0; ctlData = '0;
    check(status == 4'b1000, "R4 status after abort", status, 8);
    check(!sclOe && !sdaOe, "R4 lines released", {sclOe, sdaOe}, 0);
    ctlPulse(32'h1_0000);
    repeat (2) @(negedge clk);
    check(status == 4'b1000, "R3 run ignored after abort", status, 8);
    addC(4'h1); addC(4'h1); loadAt(63);
    check(status == 4'b0000, "R12 memory write clears flag", status, 0);
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    clearBus();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWrite();
    tRead(8'h5A, 8'hC3);
    tNack();
    tLines();
    tSleep();
    tOverrun();
    tAbort();
    tRead(8'h77, 8'h81);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule